// File: doc/BRIEF.md
# Serial Flash Continuous-Read Responder

This block is the device-side logic of a serial flash that answers array read commands. While chip select is low it shifts in an 8-bit command code, a 24-bit address and a fixed number of dummy bytes on the serial input. Each bit is sampled on a rising clock edge, most significant bit first. It then streams array bytes on the serial output, one bit per clock, from an internal address counter that advances on its own.

The address field holds a page number in its upper 13 bits and a byte offset in its lower 11 bits. The counter steps through a page, moves into the next page, and returns to page 0 after the last byte of the array. Two command pairs are recognised. The plain pair crosses pages without pause. The burst pair holds the output for a parameterised number of extra clocks at every page crossing, including the wrap at the end of the array.

Array bytes come from a synchronous read port. Each byte is requested early enough that the bit stream has no gaps at byte boundaries. Page size, page count, dummy byte count and the burst pause are parameters.

Top module: `sflash_cread`

## Requirements
- R1: While reset is asserted, so_oe is 0 and mem_rd is 0.
- R2: A command is 64 rising edges with cs_n low: code (8 bits), address (24 bits), dummy (32 bits for DUMMY_BYTES=4), all sampled from si MSB first. so_oe stays 0 for the whole header.
- R3: Address bits 23:11 give the page and bits 10:0 the byte. Each is reduced modulo NUM_PAGES and modulo PAGE_BYTES. The first output byte is the array byte at page*PAGE_BYTES+byte.
- R4: On the falling edge after the 64th rising edge, so_oe goes to 1 and so shows bit 7 of the first byte. After that, so changes only on falling edges, one bit per clock, MSB first, with no gap between bytes.
- R5: Codes 68h and E8h read continuously. The byte after the last byte of a page is byte 0 of the next page, with no extra clocks.
- R6: In continuous reading, the byte after the last byte of the last page is array byte 0, with no extra clocks.
- R7: Codes 69h and E9h read in burst mode. At every page crossing, including the array wrap, GAP_CLKS extra clocks pass while so_oe stays 1 and so holds the last bit sent. Byte 0 of the next page then follows, MSB first.
- R8: Any other code keeps so_oe at 0 until cs_n goes high.
- R9: so_oe drops to 0 as soon as cs_n rises, at any point of a command. The next low period on cs_n starts a new header.
- R10: mem_rd is only ever 1 while cs_n is low, and it is never 1 on two rising edges in a row. Read data is taken on the rising edge after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial clock; inputs are sampled on the rising edge, output changes on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial command, address and dummy input |
| so | output | 1 | Serial data output |
| so_oe | output | 1 | Output enable for so (0 = high impedance) |
| mem_rd | output | 1 | Read request to the array |
| mem_addr | output | AW | Linear array byte address, AW = clog2(PAGE_BYTES*NUM_PAGES) |
| mem_rdata | input | 8 | Array byte, valid on the rising edge after the request |

## Verification
The riskiest coincidence is a byte reload that is also a page crossing. On that one rising edge, the prefetched byte is latched and the address counter rolls into a new page, or back to address 0. In burst mode the pause counter also starts on that edge. The bench reads 36 bytes from start addresses spread across pages, offsets and out-of-range raw fields, with all four codes, so that every crossing and the array wrap land on that edge. It predicts every output bit, and every pause clock, from a byte formula and a linear-address model. A second coincidence, cs_n rising in the middle of a byte, is provoked by aborted reads and judged from so_oe and from the header that follows.

// File: rtl/sflash_cread_pkg.sv
`timescale 1ns/1ps
package sflash_cread_pkg;

   typedef enum logic [1:0] {
      ST_HDR  = 2'd0,
      ST_DATA = 2'd1,
      ST_GAP  = 2'd2,
      ST_IGN  = 2'd3
   } rd_st_e;

   localparam logic [7:0] OPC_CONT_LO  = 8'h68;
   localparam logic [7:0] OPC_CONT_HI  = 8'hE8;
   localparam logic [7:0] OPC_BURST_LO = 8'h69;
   localparam logic [7:0] OPC_BURST_HI = 8'hE9;

   function automatic logic opc_is_burst(input logic [7:0] code);
      return (code == OPC_BURST_LO) || (code == OPC_BURST_HI);
   endfunction

   function automatic logic opc_is_known(input logic [7:0] code);
      return (code == OPC_CONT_LO) || (code == OPC_CONT_HI) || opc_is_burst(code);
   endfunction

endpackage

// File: rtl/scr_ptr.sv
`timescale 1ns/1ps
// Linear array address counter with in-page byte tracking and array wrap.
module scr_ptr #(
   parameter int PAGE_BYTES = 8,
   parameter int NUM_PAGES  = 4,
   localparam int AW = $clog2(PAGE_BYTES * NUM_PAGES),
   localparam int BW = $clog2(PAGE_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [12:0]   ld_page,
   input  logic [10:0]   ld_byte,
   input  logic          adv,
   output logic [AW-1:0] addr,
   output logic          pg_start
);
   localparam int TOTAL = PAGE_BYTES * NUM_PAGES;
   localparam logic [BW-1:0] BY_LAST = BW'(PAGE_BYTES - 1);
   localparam logic [AW-1:0] A_LAST  = AW'(TOTAL - 1);

   logic [AW-1:0] lin, lin_ld;
   logic [BW-1:0] by, by_ld;

   always_comb begin
      by_ld  = BW'(int'(ld_byte) % PAGE_BYTES);
      lin_ld = AW'((int'(ld_page) % NUM_PAGES) * PAGE_BYTES + (int'(ld_byte) % PAGE_BYTES));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lin <= '0;
         by  <= '0;
      end else if (load) begin
         lin <= lin_ld;
         by  <= by_ld;
      end else if (adv) begin
         by  <= (by == BY_LAST) ? '0 : by + 1'b1;
         lin <= (lin == A_LAST) ? '0 : lin + 1'b1;
      end
   end

   assign addr     = lin;
   assign pg_start = (by == '0);
endmodule

// File: rtl/scr_sodrv.sv
`timescale 1ns/1ps
// Falling-edge output stage: launches data bits and the enable.
module scr_sodrv (
   input  logic clk,
   input  logic rst_n,
   input  logic upd,
   input  logic oe_d,
   input  logic bit_d,
   output logic so_q,
   output logic oe_q
);
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         so_q <= 1'b0;
         oe_q <= 1'b0;
      end else begin
         oe_q <= oe_d;
         if (upd) so_q <= bit_d;
      end
   end
endmodule

// File: rtl/sflash_cread.sv
`timescale 1ns/1ps
module sflash_cread
   import sflash_cread_pkg::*;
#(
   parameter int PAGE_BYTES  = 8,
   parameter int NUM_PAGES   = 4,
   parameter int GAP_CLKS    = 3,
   parameter int DUMMY_BYTES = 4,
   localparam int AW = $clog2(PAGE_BYTES * NUM_PAGES)
) (
   input  logic          sck,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          si,
   output logic          so,
   output logic          so_oe,
   output logic          mem_rd,
   output logic [AW-1:0] mem_addr,
   input  logic [7:0]    mem_rdata
);
   localparam int HDR_LEN = 32 + 8 * DUMMY_BYTES;
   localparam int CW      = $clog2(HDR_LEN);
   localparam logic [CW-1:0] C_OPC   = CW'(7);
   localparam logic [CW-1:0] C_ADR   = CW'(31);
   localparam logic [CW-1:0] C_FETCH = CW'(HDR_LEN - 2);
   localparam logic [CW-1:0] C_LAST  = CW'(HDR_LEN - 1);

   generate
      if (PAGE_BYTES < 2 || PAGE_BYTES > 2048) begin : g_bad_page
         $error("PAGE_BYTES must lie in 2..2048");
      end
      if (NUM_PAGES < 2 || NUM_PAGES > 8192) begin : g_bad_pages
         $error("NUM_PAGES must lie in 2..8192");
      end
      if (DUMMY_BYTES < 1 || GAP_CLKS < 0) begin : g_bad_misc
         $error("DUMMY_BYTES must be >= 1 and GAP_CLKS >= 0");
      end
   endgenerate

   rd_st_e        st;
   logic [CW-1:0] cnt;
   logic [22:0]   sh;
   logic          burst;
   logic [7:0]    dbyte;
   logic [2:0]    bi;
   logic [23:0]   a24;
   logic [7:0]    opc;
   logic          hdr_done, byte_end, ptr_load, ptr_adv;
   logic          pg_start, gap_go, gap_last;
   logic          so_q, oe_q;

   assign a24      = {sh, si};
   assign opc      = {sh[6:0], si};
   assign hdr_done = (st == ST_HDR) && (cnt == C_LAST);
   assign byte_end = (st == ST_DATA) && (bi == 3'd0);
   assign ptr_load = !cs_n && (st == ST_HDR) && (cnt == C_ADR);
   assign ptr_adv  = !cs_n && (hdr_done || byte_end);
   assign mem_rd   = !cs_n && (((st == ST_HDR) && (cnt == C_FETCH)) ||
                               ((st == ST_DATA) && (bi == 3'd1)));

   always_ff @(posedge sck or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_HDR;
         cnt   <= '0;
         sh    <= '0;
         burst <= 1'b0;
         dbyte <= '0;
         bi    <= 3'd7;
      end else if (cs_n) begin
         st  <= ST_HDR;
         cnt <= '0;
      end else begin
         unique case (st)
            ST_HDR: begin
               sh  <= {sh[21:0], si};
               cnt <= cnt + 1'b1;
               if (cnt == C_OPC) begin
                  burst <= opc_is_burst(opc);
                  if (!opc_is_known(opc)) st <= ST_IGN;
               end
               if (hdr_done) begin
                  st    <= ST_DATA;
                  dbyte <= mem_rdata;
                  bi    <= 3'd7;
               end
            end
            ST_DATA: begin
               if (bi == 3'd0) begin
                  dbyte <= mem_rdata;
                  bi    <= 3'd7;
                  if (gap_go) st <= ST_GAP;
               end else begin
                  bi <= bi - 1'b1;
               end
            end
            ST_GAP: if (gap_last) st <= ST_DATA;
            default: ;
         endcase
      end
   end

   generate
      if (GAP_CLKS > 0) begin : g_gap
         localparam int GW = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;
         logic [GW-1:0] gcnt;
         always_ff @(posedge sck or negedge rst_n) begin
            if (!rst_n)
               gcnt <= '0;
            else if (!cs_n && byte_end && gap_go)
               gcnt <= GW'(GAP_CLKS - 1);
            else if (st == ST_GAP && gcnt != '0)
               gcnt <= gcnt - 1'b1;
         end
         assign gap_go   = burst && pg_start;
         assign gap_last = (gcnt == '0);
      end else begin : g_nogap
         assign gap_go   = 1'b0;
         assign gap_last = 1'b1;
      end
   endgenerate

   scr_ptr #(
      .PAGE_BYTES (PAGE_BYTES),
      .NUM_PAGES  (NUM_PAGES)
   ) u_ptr (
      .clk      (sck),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .ld_page  (a24[23:11]),
      .ld_byte  (a24[10:0]),
      .adv      (ptr_adv),
      .addr     (mem_addr),
      .pg_start (pg_start)
   );

   scr_sodrv u_out (
      .clk   (sck),
      .rst_n (rst_n),
      .upd   (st == ST_DATA),
      .oe_d  ((st == ST_DATA) || (st == ST_GAP)),
      .bit_d (dbyte[bi]),
      .so_q  (so_q),
      .oe_q  (oe_q)
   );

   assign so    = so_q;
   assign so_oe = oe_q & ~cs_n;
endmodule

// File: rtl/sflash_cread_chk.sv
`timescale 1ns/1ps
module sflash_cread_chk
   import sflash_cread_pkg::*;
(
   input logic   sck,
   input logic   rst_n,
   input logic   so,
   input logic   so_oe,
   input logic   mem_rd,
   input rd_st_e st
);
   // R2: no output during the header
   a_r2_header_silent: assert property (@(posedge sck) disable iff (!rst_n)
      (st == ST_HDR) |-> !so_oe);

   // R8: an unknown code leaves the output off
   a_r8_ignore_silent: assert property (@(posedge sck) disable iff (!rst_n)
      (st == ST_IGN) |-> !so_oe);

   // R10: read requests are single pulses
   a_r10_rd_spaced: assert property (@(posedge sck) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   // R7: output bit held during a burst pause
   a_r7_gap_hold: assert property (@(negedge sck) disable iff (!rst_n)
      (st == ST_GAP) |=> $stable(so));
endmodule

bind sflash_cread sflash_cread_chk u_chk (
   .sck    (sck),
   .rst_n  (rst_n),
   .so     (so),
   .so_oe  (so_oe),
   .mem_rd (mem_rd),
   .st     (st)
);

// File: tb/sflash_cread_test.sv
`timescale 1ns/1ps
module sflash_cread_test;
   localparam int PB    = 8;
   localparam int NP    = 4;
   localparam int GAP   = 3;
   localparam int TOT   = PB * NP;
   localparam int AW    = $clog2(TOT);

   logic sck = 1'b0;
   logic rst_n, cs_n, si;
   logic so, so_oe, mem_rd;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_rdata = 8'h00;

   int total = 0;
   int bad = 0;
   int rd_bad = 0;

   always #2.5 sck = ~sck;

   function automatic logic [7:0] memb(input int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   always @(posedge sck) begin
      if (mem_rd) mem_rdata <= memb(int'(mem_addr));
      if (mem_rd && cs_n) rd_bad++;
   end

   sflash_cread #(
      .PAGE_BYTES (PB),
      .NUM_PAGES  (NP),
      .GAP_CLKS   (GAP),
      .DUMMY_BYTES(4)
   ) uut (
      .sck       (sck),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .si        (si),
      .so        (so),
      .so_oe     (so_oe),
      .mem_rd    (mem_rd),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic do_read(input logic [7:0] opc, input int praw, input int braw, input int nbits);
      logic [63:0] hdr;
      logic [7:0]  cur;
      logic        known, is_b, prev, e;
      int          lin, bi, gap, sent, cyc;
      bit          first, wrapped;
      string       tag;
      known = (opc == 8'h68) || (opc == 8'hE8) || (opc == 8'h69) || (opc == 8'hE9);
      is_b  = (opc == 8'h69) || (opc == 8'hE9);
      hdr   = {opc, 13'(praw), 11'(braw), 32'h0};
      @(negedge sck); #1;
      cs_n = 1'b0;
      for (int i = 63; i >= 0; i--) begin
         if (i != 63) begin @(negedge sck); #1; end
         si = hdr[i];
         chk(known ? "R2" : "R8", so_oe, 1'b0);
      end
      if (!known) begin
         repeat (nbits) begin
            @(negedge sck); #1;
            si = 1'b0;
            chk("R8", so_oe, 1'b0);
         end
      end else begin
         lin = (praw % NP) * PB + (braw % PB);
         bi = 7; gap = 0; sent = 0; cyc = 0; prev = 1'b0;
         first = 1'b1; wrapped = 1'b0;
         while (sent < nbits) begin
            @(negedge sck); #1;
            si = 1'b0;
            if (gap > 0) begin
               e = prev;
               gap--;
               tag = "R7";
            end else begin
               cur  = memb(lin);
               e    = cur[bi];
               prev = e;
               sent++;
               tag  = first ? "R3" : (is_b ? "R7" : (wrapped ? "R6" : "R5"));
               if (bi == 0) begin
                  bi = 7;
                  first = 1'b0;
                  lin = lin + 1;
                  if (lin == TOT) begin lin = 0; wrapped = 1'b1; end
                  if (is_b && (lin % PB) == 0) gap = GAP;
               end else begin
                  bi--;
               end
            end
            chk((cyc == 0) ? "R4" : tag, so_oe, 1'b1);
            chk((cyc == 0) ? "R4" : tag, so, e);
            cyc++;
         end
      end
      @(negedge sck); #1;
      cs_n = 1'b1;
      si = 1'b0;
      #0.2;
      chk("R9", so_oe, 1'b0);
      @(negedge sck);
   endtask

   initial begin : watchdog
      repeat (195000) @(posedge sck);
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [7:0] ops [4];
      ops[0] = 8'h68; ops[1] = 8'hE8; ops[2] = 8'h69; ops[3] = 8'hE9;
      rst_n = 1'b0;
      cs_n  = 1'b1;
      si    = 1'b0;
      repeat (3) @(negedge sck);
      #1;
      chk("R1", so_oe, 1'b0);
      chk("R1", mem_rd, 1'b0);
      rst_n = 1'b1;
      @(negedge sck);

      // R3 R5 R6 R7: every start in range and several out-of-range raw fields
      for (int o = 0; o < 4; o++)
         for (int p = 0; p < 6; p++)
            for (int b = 0; b < 11; b++)
               do_read(ops[o], p, b, 36 * 8);

      // R3: large raw fields reduced modulo
      do_read(8'h68, 13'h1FFF, 11'h7FF, 40);
      do_read(8'h69, 13'h1005, 11'h40D, 80);

      // R8: unknown codes
      do_read(8'h67, 1, 2, 100);
      do_read(8'h6A, 0, 0, 100);
      do_read(8'hE7, 3, 7, 100);
      do_read(8'h00, 2, 5, 100);

      // R9: aborts in the middle of a byte, then fresh commands
      do_read(8'hE8, 1, 6, 13);
      do_read(8'h69, 2, 7, 5);
      do_read(8'hE9, 0, 7, 11);
      do_read(8'h68, 3, 3, 16);

      // R10: read requests only while selected
      chk("R10", rd_bad != 0, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule